// File: doc/BRIEF.md
# Trace Record Packer

The block turns a stream of CPU trace events into lines of a 64-bit-wide trace store. Each event strobe, or each change-of-flow strobe, writes one record at the position given by an entry counter. The counter's low bit selects a half line and its upper bits select the line. An arm pulse latches the capture mode, clears the counter and the valid flags, and starts capture.

In the compact modes (normal, loop and pure-PC), a record is 32 bits: an info byte above a 24-bit program counter. Two records share one line. In detail mode, a record holds an info byte, a 24-bit address and two data bytes, and it fills a whole line. The store has 64 lines. When the counter passes the last line, a full flag is set and capture wraps round over the oldest line. A combinational read port shows any line together with its two valid flags.

Top module: `trc_pack`

## Requirements
- R1: In a compact mode, a record is `{info_i, addr_i}`: the info byte sits in bits 31:24 of its half line and the 24-bit PC sits in bits 23:0.
- R2: In a compact mode, every record increments `cnt_o` by one. When `cnt_o[0]`=0, the record goes to line bytes 3..0 of line `cnt_o[6:1]`. When `cnt_o[0]`=1, it goes to bytes 7..4.
- R3: In detail mode, `cnt_o[0]` stays 0 and every record increments `cnt_o[6:1]` by one.
- R4: A detail line holds the info byte in byte 7, the address in bytes 6..4 (high to low) and data in bytes 3..2. Bytes 1..0 are zero.
- R5: For a detail byte access (`word_i`=0), byte 2 = `data_i[7:0]` and byte 3 = 0.
- R6: For a detail word access (`word_i`=1), byte 3 = `data_i[15:8]` (the lower-address byte) and byte 2 = `data_i[7:0]` (the higher-address byte).
- R7: `cof_i` alone writes a record. `rd_valid_o[0]` flags the low half and `rd_valid_o[1]` flags the high half. A compact record sets the bit of its half, and a detail record sets both bits.
- R8: A cycle with neither strobe leaves the counter and the store unchanged. Strobes before the first arm are ignored.
- R9: When the line field wraps from 63 to 0, `full_o` is set and capture overwrites line 0. A compact write to the low half clears that line's high-half valid bit.
- R10: `arm_i` clears the counter, all valid bits and `full_o`, and it latches `mode_i`. Changes to `mode_i` while armed have no effect until the next arm. A strobe in the arm cycle is dropped.
- R11: Mode codes are 0 normal, 1 loop, 2 detail and 3 pure-PC. Loop and pure-PC pack records exactly as normal mode does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm pulse: clear and latch mode |
| mode_i | input | 2 | Capture mode code |
| evt_i | input | 1 | Trace event strobe |
| cof_i | input | 1 | Change-of-flow strobe |
| addr_i | input | 24 | PC or access address |
| data_i | input | 16 | Access data, lower-address byte in 15:8 |
| word_i | input | 1 | 1 for a word access, 0 for a byte access |
| info_i | input | 8 | Info byte for the record |
| rd_idx_i | input | 6 | Line to read |
| rd_line_o | output | 64 | Contents of the selected line |
| rd_valid_o | output | 2 | Valid flags of the selected line's halves |
| cnt_o | output | 7 | Entry counter: line in 6:1, half in 0 |
| full_o | output | 1 | Set once the line field has wrapped |

## Verification
A wrong counter shows up in the first cycle after the record that corrupted it: `cnt_o` stops matching the number of records, and the next record lands in the wrong half or line, which a readback exposes. A latched mode that drifts shows up as a counter that steps by two instead of one, or the reverse, on the very next strobe. A lane or valid-flag fault only appears when the affected line is read, so every scenario reads back each line it wrote and compares it with the full 64-bit value.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_LOOP   = 2'd1,
    MODE_DETAIL = 2'd2,
    MODE_PURE   = 2'd3
  } trc_mode_e;
endpackage

// File: rtl/trc_fmt.sv
module trc_fmt #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int INFO_W = 8,
  parameter int LINE_W = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              word_i,
  input  logic [INFO_W-1:0] info_i,
  output logic [LINE_W/2-1:0] half_rec_o,
  output logic [LINE_W-1:0]   full_rec_o
);
  localparam int HALF_W = LINE_W / 2;
  localparam int LANE_W = DATA_W / 2;
  localparam int PAD_W  = LINE_W - INFO_W - ADDR_W - DATA_W;

  logic [LANE_W-1:0] hi_lane;
  logic [LANE_W-1:0] lo_lane;

  // byte access: only the low lane carries data
  assign hi_lane = word_i ? data_i[DATA_W-1:LANE_W] : '0;
  assign lo_lane = data_i[LANE_W-1:0];

  assign half_rec_o = HALF_W'({info_i, addr_i});
  assign full_rec_o = {info_i, addr_i, hi_lane, lo_lane, {PAD_W{1'b0}}};
endmodule

// File: rtl/trc_ptr.sv
module trc_ptr #(
  parameter int AW = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        rec_i,
  input  logic        detail_i,
  output logic [AW:0] cnt_o,
  output logic        full_o
);
  logic [AW:0]   cnt_q;
  logic [AW-1:0] line_nx;
  logic          wrap;

  assign line_nx = cnt_q[AW:1] + 1'b1;
  assign wrap    = detail_i ? &cnt_q[AW:1] : &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      full_o <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      full_o <= 1'b0;
    end else if (rec_i) begin
      cnt_q  <= detail_i ? {line_nx, 1'b0} : cnt_q + 1'b1;
      full_o <= full_o | wrap;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/trc_mem.sv
module trc_mem #(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int HALF_W = LINE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [1:0]        wr_en_i,
  input  logic [AW-1:0]     wr_idx_i,
  input  logic [LINE_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [LINE_W-1:0] rd_data_o,
  output logic [1:0]        rd_vld_o
);
  logic [1:0] vld_q [DEPTH];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HALF_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (wr_en_i[h]) mem_q[wr_idx_i] <= wr_data_i[h*HALF_W +: HALF_W];
    end
    assign rd_data_o[h*HALF_W +: HALF_W] = mem_q[rd_idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) vld_q[i] <= '0;
    end else if (clr_i) begin
      for (int i = 0; i < DEPTH; i++) vld_q[i] <= '0;
    end else if (|wr_en_i) begin
      // low-half write starts a fresh line; high-half write adds to it
      vld_q[wr_idx_i] <= (wr_en_i == 2'b10) ? (vld_q[wr_idx_i] | 2'b10) : wr_en_i;
    end
  end

  assign rd_vld_o = vld_q[rd_idx_i];
endmodule

// File: rtl/trc_pack.sv
module trc_pack
  import trc_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int INFO_W = 8,
  parameter int LINE_W = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [1:0]        mode_i,
  input  logic              evt_i,
  input  logic              cof_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              word_i,
  input  logic [INFO_W-1:0] info_i,
  input  logic [AW-1:0]     rd_idx_i,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [1:0]        rd_valid_o,
  output logic [AW:0]       cnt_o,
  output logic              full_o
);
  localparam int HALF_W = LINE_W / 2;

  trc_mode_e mode_q;
  logic      armed_q;
  logic      rec;
  logic      detail;
  logic [1:0]        wr_en;
  logic [LINE_W-1:0] wr_data;
  logic [HALF_W-1:0] half_rec;
  logic [LINE_W-1:0] full_rec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_NORMAL;
      armed_q <= 1'b0;
    end else if (arm_i) begin
      mode_q  <= trc_mode_e'(mode_i);
      armed_q <= 1'b1;
    end
  end

  assign rec    = armed_q & ~arm_i & (evt_i | cof_i);
  assign detail = (mode_q == MODE_DETAIL);

  always_comb begin
    wr_en = 2'b00;
    if (rec) wr_en = detail ? 2'b11 : (cnt_o[0] ? 2'b10 : 2'b01);
  end

  assign wr_data = detail ? full_rec : {half_rec, half_rec};

  trc_fmt #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INFO_W(INFO_W), .LINE_W(LINE_W)
  ) u_fmt (
    .addr_i    (addr_i),
    .data_i    (data_i),
    .word_i    (word_i),
    .info_i    (info_i),
    .half_rec_o(half_rec),
    .full_rec_o(full_rec)
  );

  trc_ptr #(.AW(AW)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (arm_i),
    .rec_i   (rec),
    .detail_i(detail),
    .cnt_o   (cnt_o),
    .full_o  (full_o)
  );

  trc_mem #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (arm_i),
    .wr_en_i  (wr_en),
    .wr_idx_i (cnt_o[AW:1]),
    .wr_data_i(wr_data),
    .rd_idx_i (rd_idx_i),
    .rd_data_o(rd_line_o),
    .rd_vld_o (rd_valid_o)
  );
endmodule

// File: rtl/trc_pack_chk.sv
module trc_pack_chk #(
  parameter int AW = 6
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        arm_i,
  input logic        evt_i,
  input logic        cof_i,
  input logic        armed_i,
  input logic        detail_i,
  input logic [AW:0] cnt_o,
  input logic        full_o
);
  logic rec;
  assign rec = armed_i & ~arm_i & (evt_i | cof_i);

  a_r2_compact_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec && !detail_i) |=> cnt_o == $past(cnt_o) + 1'b1);

  a_r3_detail_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec && detail_i) |=> cnt_o == $past(cnt_o) + 2'd2);

  a_r3_detail_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detail_i |-> !cnt_o[0]);

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec && !arm_i) |=> ($stable(cnt_o) && $stable(full_o)));

  a_r9_full_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> cnt_o[AW:1] == '0);

  a_r10_arm_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (cnt_o == '0 && !full_o));

  a_r10_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> $stable(detail_i));
endmodule

bind trc_pack trc_pack_chk #(.AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .arm_i   (arm_i),
  .evt_i   (evt_i),
  .cof_i   (cof_i),
  .armed_i (armed_q),
  .detail_i(detail),
  .cnt_o   (cnt_o),
  .full_o  (full_o)
);

// File: tb/tb_trc_pack.sv
`timescale 1ns/1ps
module tb_trc_pack;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        arm_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        evt_i = 1'b0;
  logic        cof_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic        word_i = 1'b0;
  logic [7:0]  info_i = '0;
  logic [5:0]  rd_idx_i = '0;
  logic [63:0] rd_line_o;
  logic [1:0]  rd_valid_o;
  logic [6:0]  cnt_o;
  logic        full_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  trc_pack dut (.*);

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic arm(input logic [1:0] m);
    @(negedge clk_i);
    arm_i = 1'b1; mode_i = m;
    @(negedge clk_i);
    arm_i = 1'b0;
  endtask

  task automatic put(input logic e, input logic c, input logic [23:0] a,
                     input logic [15:0] d, input logic w, input logic [7:0] inf);
    @(negedge clk_i);
    evt_i = e; cof_i = c; addr_i = a; data_i = d; word_i = w; info_i = inf;
    @(negedge clk_i);
    evt_i = 1'b0; cof_i = 1'b0;
  endtask

  task automatic peek(input logic [5:0] idx);
    rd_idx_i = idx;
    #1;
  endtask

  task automatic t_reset;
    chk("R10 reset cnt", 64'(cnt_o), 64'd0);
    chk("R10 reset full", 64'(full_o), 64'd0);
    put(1, 0, 24'h111111, 16'h0, 0, 8'h01);
    chk("R8 pre-arm cnt", 64'(cnt_o), 64'd0);
    peek(0);
    chk("R8 pre-arm valid", 64'(rd_valid_o), 64'd0);
  endtask

  task automatic t_normal;
    arm(2'd0);
    put(1, 0, 24'h0A0B0C, 16'h0, 0, 8'h11);
    put(1, 0, 24'h0D0E0F, 16'h0, 0, 8'h22);
    put(1, 0, 24'h102030, 16'h0, 0, 8'h33);
    peek(0);
    chk("R1 R2 line0 packed", rd_line_o, 64'h220D0E0F_110A0B0C);
    chk("R7 line0 valid", 64'(rd_valid_o), 64'd3);
    peek(1);
    chk("R2 line1 low half", {32'h0, rd_line_o[31:0]}, 64'h33102030);
    chk("R7 line1 valid", 64'(rd_valid_o), 64'd1);
    chk("R2 cnt", 64'(cnt_o), 64'd3);
  endtask

  task automatic t_idle;
    repeat (3) @(negedge clk_i);
    chk("R8 idle cnt", 64'(cnt_o), 64'd3);
    peek(1);
    chk("R8 idle valid", 64'(rd_valid_o), 64'd1);
  endtask

  task automatic t_loop_pure;
    arm(2'd1);
    chk("R10 arm clears cnt", 64'(cnt_o), 64'd0);
    peek(0);
    chk("R10 arm clears valid", 64'(rd_valid_o), 64'd0);
    put(1, 0, 24'hABCDEF, 16'hFFFF, 1, 8'h44);
    peek(0);
    chk("R11 loop format", {32'h0, rd_line_o[31:0]}, 64'h44ABCDEF);
    chk("R11 loop cnt", 64'(cnt_o), 64'd1);
    arm(2'd3);
    put(1, 0, 24'h123456, 16'h0, 0, 8'h55);
    put(1, 0, 24'h654321, 16'h0, 0, 8'h66);
    peek(0);
    chk("R11 pure-PC format", rd_line_o, 64'h66654321_55123456);
    chk("R11 pure-PC cnt", 64'(cnt_o), 64'd2);
  endtask

  task automatic t_detail;
    arm(2'd2);
    put(1, 0, 24'h123456, 16'hBEEF, 1, 8'hA5);
    peek(0);
    chk("R4 R6 detail word", rd_line_o, 64'hA5123456_BEEF0000);
    chk("R7 detail valid", 64'(rd_valid_o), 64'd3);
    chk("R3 detail cnt", 64'(cnt_o), 64'd2);
    put(1, 0, 24'h00FF01, 16'hBEEF, 0, 8'h5A);
    peek(1);
    chk("R5 detail byte", rd_line_o, 64'h5A00FF01_00EF0000);
    chk("R3 detail cnt two", 64'(cnt_o), 64'd4);
  endtask

  task automatic t_cof;
    arm(2'd0);
    put(0, 1, 24'h777777, 16'h0, 0, 8'h80);
    chk("R7 cof cnt", 64'(cnt_o), 64'd1);
    peek(0);
    chk("R7 cof valid", 64'(rd_valid_o), 64'd1);
    chk("R7 cof data", {32'h0, rd_line_o[31:0]}, 64'h80777777);
  endtask

  task automatic t_mode_hold;
    arm(2'd0);
    @(negedge clk_i);
    mode_i = 2'd2;
    put(1, 0, 24'h000001, 16'hAAAA, 1, 8'h01);
    put(1, 0, 24'h000002, 16'hAAAA, 1, 8'h02);
    chk("R10 mode held cnt", 64'(cnt_o), 64'd2);
    peek(0);
    chk("R10 mode held line", rd_line_o, 64'h02000002_01000001);
    // strobe in the arm cycle is dropped
    @(negedge clk_i);
    arm_i = 1'b1; mode_i = 2'd0; evt_i = 1'b1;
    @(negedge clk_i);
    arm_i = 1'b0; evt_i = 1'b0;
    chk("R10 arm-cycle strobe dropped", 64'(cnt_o), 64'd0);
  endtask

  task automatic t_wrap;
    arm(2'd0);
    for (int i = 0; i < 128; i++) put(1, 0, 24'(i), 16'h0, 0, 8'hC0);
    chk("R9 wrap cnt", 64'(cnt_o), 64'd0);
    chk("R9 full set", 64'(full_o), 64'd1);
    peek(63);
    chk("R9 last line", rd_line_o, 64'hC000007F_C000007E);
    put(1, 0, 24'hFEDCBA, 16'h0, 0, 8'hD1);
    peek(0);
    chk("R9 overwrite low", {32'h0, rd_line_o[31:0]}, 64'hD1FEDCBA);
    chk("R9 stale high invalid", 64'(rd_valid_o), 64'd1);
    chk("R9 full stays", 64'(full_o), 64'd1);
    arm(2'd0);
    chk("R10 arm clears full", 64'(full_o), 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_normal;
    t_idle;
    t_loop_pure;
    t_detail;
    t_cof;
    t_mode_hold;
    t_wrap;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule